// File: doc/BRIEF.md
# Sequential Multiply, Divide and Shift Engine

This block is the slow-arithmetic companion of a 12-bit accumulator machine. When a command is accepted, the engine takes a copy of the accumulator (AC), the multiplier-quotient register (MQ) and the carry flag (link). It then works on AC and MQ as one 24-bit pair, with AC as the high half, and moves one bit of the result per clock. It supports unsigned multiply, unsigned divide, normalize, and three pair shifts. The engine keeps its own 5-bit step counter. Normalize writes it; every other command leaves it alone.

The instruction fetch logic supplies each command together with a 12-bit operand word. For multiply and divide that word is the second factor or the divisor. For the three shifts it holds the shift distance minus one. Normalize ignores it. While the engine works, `busy_o` is high and new starts are dropped. `done_o` pulses for one cycle when the registered AC, MQ, link and step-count outputs hold the result.

Top module: `eae_unit`

## Requirements
- R1: After reset `busy_o` and `done_o` are low, and `ac_o`, `mq_o`, `link_o` and `sc_o` are all zero.
- R2: Command code 0 (multiply) leaves the unsigned product MQ×operand with its high 12 bits in AC and its low 12 bits in MQ. The AC input value plays no part. Link ends at 0. Exactly 12 cycles with `busy_o` high and `done_o` low come before the `done_o` cycle.
- R3: Command code 1 (divide) with AC below the operand divides the unsigned 24-bit pair AC:MQ by the operand. The quotient goes to MQ and the remainder to AC, link ends at 0, and exactly 12 busy cycles come before `done_o`.
- R4: Command code 1 with AC greater than or equal to the operand is an overflow. This includes an operand of zero. Link ends at 1, AC and MQ keep the accepted values, and `done_o` comes in the first cycle after the accepting edge.
- R5: Command code 3 shifts the pair left by operand+1 places and fills with zeros. Link receives the last bit shifted out of AC bit 11.
- R6: Command code 4 shifts the pair right by operand+1 places and copies AC bit 11 into the vacated bits. Command code 5 does the same but fills with zeros. For both, link receives the last bit shifted out of MQ bit 0.
- R7: Command code 2 (normalize) shifts the pair left until one of these holds: AC bits 11 and 10 differ; AC bits 11:10 are both 1 and every other bit of the pair is 0; or the pair is 0. `sc_o` is set to the number of shifts, and link is unchanged.
- R8: A normalize that starts on a pair that already meets a stop condition, including the all-zero pair, ends with `sc_o` equal to 0 and the pair unchanged.
- R9: Commands other than normalize leave `sc_o` unchanged.
- R10: `busy_o` is high from the cycle after the accepting edge through the single `done_o` cycle. A start while `busy_o` is high is ignored.
- R11: A start with command code 6 or 7 is ignored: `busy_o` stays low and the outputs keep their values.
- R12: A shift takes min(operand+1, 25) busy cycles before `done_o`. Operands of 24 or more give the same result as an unbounded shift of operand+1 places.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request, taken when the engine is idle |
| op_i | input | 3 | Command code: 0 mul, 1 div, 2 normalize, 3 shift left, 4 arithmetic right, 5 logical right |
| operand_i | input | 12 | Operand word supplied by fetch |
| ac_i | input | 12 | Accumulator value copied at accept |
| mq_i | input | 12 | MQ value copied at accept |
| link_i | input | 1 | Link value copied at accept |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ac_o | output | 12 | Accumulator result |
| mq_o | output | 12 | MQ result |
| link_o | output | 1 | Link result |
| sc_o | output | 5 | Step counter |

## Verification
The bench builds the engine with its default parameters: a 12-bit word, which gives a 24-bit pair, and a 5-bit step counter. At this word size, every operand from 0 up to the 25-place shift cap can be reached directly. So can the longest normalize, 22 shifts, which still fits the step counter. The divide bench drives AC both below and at or above the divisor, including a divisor of zero, so that both the iterating path and the overflow path run many times. Directed cases cover the all-zero pair, the all-ones pair, the 11 followed by zeros pattern, a start injected in mid-run, and the unused command codes.

// File: rtl/eae_pkg.sv
package eae_pkg;
  typedef enum logic [2:0] {
    OP_MUL = 3'd0,
    OP_DIV = 3'd1,
    OP_NMZ = 3'd2,
    OP_SHL = 3'd3,
    OP_ASR = 3'd4,
    OP_LSR = 3'd5
  } eae_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } eae_state_e;

  function automatic logic op_valid(input logic [2:0] op);
    return op <= 3'd5;
  endfunction
endpackage

// File: rtl/eae_norm_detect.sv
module eae_norm_detect #(
  parameter int unsigned PW = 24
) (
  input  logic [PW-1:0] pair_i,
  output logic          stop_o
);
  logic top_differ, neg_pow, all_zero;

  always_comb begin
    top_differ = pair_i[PW-1] ^ pair_i[PW-2];
    neg_pow    = (pair_i[PW-1:PW-2] == 2'b11) && (pair_i[PW-3:0] == '0);
    all_zero   = (pair_i == '0);
    stop_o     = top_differ | neg_pow | all_zero;
  end
endmodule

// File: rtl/eae_ctrl.sv
module eae_ctrl
  import eae_pkg::*;
#(
  parameter int unsigned W    = 12,
  parameter int unsigned PW   = 2 * W,
  parameter int unsigned CNTW = $clog2(((PW > W) ? PW : W) + 2)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] operand_i,
  input  logic         div_ovf_i,
  input  logic         norm_stop_i,
  output logic         load_o,
  output logic         step_o,
  output eae_op_e      op_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int unsigned SHIFT_CAP = PW + 1;
  localparam int unsigned RLW       = CNTW + 1;

  eae_state_e      state_q;
  eae_op_e         op_q;
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] iter;
  logic            finish;

  assign load_o = (state_q == ST_IDLE) && start_i && op_valid(op_i);

  always_comb begin
    unique case (op_i)
      3'd0, 3'd1: iter = CNTW'(W);
      3'd3, 3'd4, 3'd5:
        iter = (operand_i >= W'(PW)) ? CNTW'(SHIFT_CAP) : (CNTW'(operand_i) + CNTW'(1));
      default: iter = CNTW'(1);
    endcase
  end

  assign step_o = (state_q == ST_RUN) && !((op_q == OP_NMZ) && norm_stop_i);
  assign finish = (state_q == ST_RUN) &&
                  ((op_q == OP_NMZ) ? norm_stop_i : (cnt_q == CNTW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_MUL;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          op_q  <= eae_op_e'(op_i);
          cnt_q <= iter;
          state_q <= ((op_i == 3'd1) && div_ovf_i) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          if (step_o && (op_q != OP_NMZ)) cnt_q <= cnt_q - CNTW'(1);
          if (finish) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign op_o   = op_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  // run-length monitor for iteration-count checks
  logic [RLW-1:0] run_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_len_q <= '0;
    else if (load_o) run_len_q <= '0;
    else if (state_q == ST_RUN) run_len_q <= run_len_q + RLW'(1);
  end

  p_mul_iter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_MUL) |-> run_len_q == RLW'(W));

  p_div_iter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_DIV) |-> (run_len_q == RLW'(W) || run_len_q == '0));

  p_shift_cap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_SHL || op_q == OP_ASR || op_q == OP_LSR))
      |-> (run_len_q != '0 && run_len_q <= RLW'(SHIFT_CAP)));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> $stable(op_q));
endmodule

// File: rtl/eae_dpath.sv
module eae_dpath
  import eae_pkg::*;
#(
  parameter int unsigned W   = 12,
  parameter int unsigned SCW = 5,
  parameter int unsigned PW  = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [2:0]    load_op_i,
  input  logic          div_ovf_i,
  input  logic          step_i,
  input  logic          done_i,
  input  eae_op_e       op_i,
  input  logic [W-1:0]  operand_i,
  input  logic [W-1:0]  ac_i,
  input  logic [W-1:0]  mq_i,
  input  logic          link_i,
  output logic [W-1:0]  ac_o,
  output logic [W-1:0]  mq_o,
  output logic          link_o,
  output logic [SCW-1:0] sc_o,
  output logic [PW-1:0] pair_o
);
  logic [W-1:0]   ac_q, mq_q, opnd_q;
  logic           link_q;
  logic [SCW-1:0] sc_q;

  logic [W-1:0] ac_n, mq_n;
  logic         link_n;
  logic [W:0]   mul_sum, div_rem, div_dif;
  logic         div_ge;
  logic         load_link;

  always_comb begin
    mul_sum = {1'b0, ac_q} + (mq_q[0] ? {1'b0, opnd_q} : '0);
    div_rem = {ac_q, mq_q[W-1]};
    div_ge  = div_rem >= {1'b0, opnd_q};
    div_dif = div_ge ? (div_rem - {1'b0, opnd_q}) : div_rem;
  end

  always_comb begin
    ac_n   = ac_q;
    mq_n   = mq_q;
    link_n = link_q;
    unique case (op_i)
      OP_MUL: begin
        ac_n = mul_sum[W:1];
        mq_n = {mul_sum[0], mq_q[W-1:1]};
      end
      OP_DIV: begin
        ac_n = div_dif[W-1:0];
        mq_n = {mq_q[W-2:0], div_ge};
      end
      OP_NMZ: begin
        ac_n = {ac_q[W-2:0], mq_q[W-1]};
        mq_n = {mq_q[W-2:0], 1'b0};
      end
      OP_SHL: begin
        link_n = ac_q[W-1];
        ac_n   = {ac_q[W-2:0], mq_q[W-1]};
        mq_n   = {mq_q[W-2:0], 1'b0};
      end
      OP_ASR, OP_LSR: begin
        link_n = mq_q[0];
        ac_n   = {(op_i == OP_ASR) ? ac_q[W-1] : 1'b0, ac_q[W-1:1]};
        mq_n   = {ac_q[0], mq_q[W-1:1]};
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (load_op_i)
      3'd0:    load_link = 1'b0;
      3'd1:    load_link = div_ovf_i;
      default: load_link = link_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q   <= '0;
      mq_q   <= '0;
      opnd_q <= '0;
      link_q <= 1'b0;
      sc_q   <= '0;
    end else if (load_i) begin
      ac_q   <= (load_op_i == 3'd0) ? '0 : ac_i;
      mq_q   <= mq_i;
      opnd_q <= operand_i;
      link_q <= load_link;
      if (load_op_i == 3'd2) sc_q <= '0;
    end else if (step_i) begin
      ac_q   <= ac_n;
      mq_q   <= mq_n;
      link_q <= link_n;
      if (op_i == OP_NMZ) sc_q <= sc_q + SCW'(1);
    end
  end

  assign ac_o   = ac_q;
  assign mq_o   = mq_q;
  assign link_o = link_q;
  assign sc_o   = sc_q;
  assign pair_o = {ac_q, mq_q};

  p_div_rem_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && op_i == OP_DIV && !link_q) |-> (ac_q < opnd_q));

  p_div_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && op_i == OP_DIV && link_q) |-> (ac_q >= opnd_q));

  p_mul_link_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && op_i == OP_MUL) |-> !link_q);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable({ac_q, mq_q, link_q, sc_q}));

  p_sc_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && op_i != OP_NMZ) |=> $stable(sc_q));
endmodule

// File: rtl/eae_unit.sv
module eae_unit
  import eae_pkg::*;
#(
  parameter int unsigned W   = 12,
  parameter int unsigned SCW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2:0]     op_i,
  input  logic [W-1:0]   operand_i,
  input  logic [W-1:0]   ac_i,
  input  logic [W-1:0]   mq_i,
  input  logic           link_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [W-1:0]   ac_o,
  output logic [W-1:0]   mq_o,
  output logic           link_o,
  output logic [SCW-1:0] sc_o
);
  localparam int unsigned PW = 2 * W;

  logic          load, step, div_ovf, norm_stop;
  eae_op_e       op_q;
  logic [PW-1:0] pair;

  assign div_ovf = ac_i >= operand_i;

  eae_norm_detect #(.PW(PW)) u_norm (
    .pair_i (pair),
    .stop_o (norm_stop)
  );

  eae_ctrl #(.W(W), .PW(PW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .op_i        (op_i),
    .operand_i   (operand_i),
    .div_ovf_i   (div_ovf),
    .norm_stop_i (norm_stop),
    .load_o      (load),
    .step_o      (step),
    .op_o        (op_q),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  eae_dpath #(.W(W), .SCW(SCW), .PW(PW)) u_dpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_op_i (op_i),
    .div_ovf_i (div_ovf),
    .step_i    (step),
    .done_i    (done_o),
    .op_i      (op_q),
    .operand_i (operand_i),
    .ac_i      (ac_i),
    .mq_i      (mq_i),
    .link_i    (link_i),
    .ac_o      (ac_o),
    .mq_o      (mq_o),
    .link_o    (link_o),
    .sc_o      (sc_o),
    .pair_o    (pair)
  );

  p_norm_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_NMZ) |-> norm_stop);

  p_invalid_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && op_i > 3'd5) |=> !busy_o);
endmodule

// File: tb/eae_unit_tb.sv
module eae_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [11:0] operand_i = '0, ac_i = '0, mq_i = '0;
  logic        link_i = 1'b0;
  logic        busy_o, done_o, link_o;
  logic [11:0] ac_o, mq_o;
  logic [4:0]  sc_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [4:0] sc_model = '0;

  always #2 clk_i = ~clk_i;

  eae_unit u_dut (
    .clk_i, .rst_ni, .start_i, .op_i, .operand_i, .ac_i, .mq_i, .link_i,
    .busy_o, .done_o, .ac_o, .mq_o, .link_o, .sc_o
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic norm_stop(input logic [23:0] p);
    return (p[23] ^ p[22]) || (p[23:22] == 2'b11 && p[21:0] == 0) || (p == 0);
  endfunction

  task automatic model(input logic [2:0] op, input logic [11:0] opd,
                       input logic [11:0] ac, input logic [11:0] mq, input logic lk,
                       output logic [11:0] eac, output logic [11:0] emq,
                       output logic elk, output logic [4:0] esc,
                       output int ecyc, output string req);
    logic [23:0] p;
    int n;
    p = {ac, mq}; elk = lk; esc = sc_model;
    case (op)
      3'd0: begin p = mq * opd; elk = 1'b0; ecyc = 12; req = "R2"; end
      3'd1: if (ac >= opd) begin elk = 1'b1; ecyc = 0; req = "R4"; end
            else begin
              p = {24'(({ac, mq} % opd)) , 24'(0)} >> 24;
              p = {12'(({ac, mq} % opd)), 12'(({ac, mq} / opd))};
              elk = 1'b0; ecyc = 12; req = "R3";
            end
      3'd2: begin
        n = 0;
        while (!norm_stop(p)) begin p = p << 1; n++; end
        esc = 5'(n); ecyc = n + 1; req = (n == 0) ? "R8" : "R7";
      end
      default: begin
        n = int'(opd) + 1;
        for (int i = 0; i < n; i++) begin
          if (op == 3'd3) begin elk = p[23]; p = p << 1; end
          else begin elk = p[0]; p = {(op == 3'd4) ? p[23] : 1'b0, p[23:1]}; end
        end
        ecyc = (n > 25) ? 25 : n;
        req = (opd >= 24) ? "R12" : ((op == 3'd3) ? "R5" : "R6");
      end
    endcase
    eac = p[23:12]; emq = p[11:0];
  endtask

  task automatic run(input logic [2:0] op, input logic [11:0] opd,
                     input logic [11:0] ac, input logic [11:0] mq, input logic lk,
                     input bit poke);
    logic [11:0] eac, emq; logic elk; logic [4:0] esc;
    int ecyc, n;
    string req;
    model(op, opd, ac, mq, lk, eac, emq, elk, esc, ecyc, req);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; operand_i = opd; ac_i = ac; mq_i = mq; link_i = lk;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 1000) begin
      if (poke && n == 3) begin
        start_i = 1'b1; op_i = 3'd3; operand_i = 12'd2; ac_i = 12'hfff; mq_i = 12'hfff;
      end else start_i = 1'b0;
      if (busy_o) n++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    check({req, " result"}, {esc, elk, ac_o, mq_o, sc_o}, {esc, elk, eac, emq, esc});
    check({req, " R10 busy cycles"}, 64'(n), 64'(ecyc));
    check("R10 busy in done cycle", 64'(busy_o), 64'd1);
    sc_model = esc;
    @(negedge clk_i);
    check("R10 idle after done", 64'({busy_o, done_o}), 64'd0);
  endtask

  initial begin
    logic [11:0] a, b, c;
    logic [2:0] o;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    check("R1 reset state", {ac_o, mq_o, link_o, sc_o, busy_o, done_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run(3'd0, 12'hfff, 12'h123, 12'hfff, 1'b1, 0);   // R2 max product
    run(3'd0, 12'd0, 12'h555, 12'h7ab, 1'b1, 0);     // R2 zero factor
    run(3'd1, 12'hfff, 12'hffe, 12'hfff, 1'b1, 0);   // R3 largest quotient
    run(3'd1, 12'd7, 12'd0, 12'd100, 1'b0, 0);       // R3
    run(3'd1, 12'd0, 12'd0, 12'h321, 1'b0, 0);       // R4 divide by zero
    run(3'd1, 12'd5, 12'd5, 12'h321, 1'b0, 0);       // R4 equal
    run(3'd2, 12'd0, 12'd0, 12'd1, 1'b1, 0);         // R7 longest normalize
    run(3'd2, 12'd0, 12'd0, 12'd0, 1'b1, 0);         // R8 zero pair
    run(3'd2, 12'd0, 12'hc00, 12'd0, 1'b0, 0);       // R8 11 then zeros
    run(3'd2, 12'd0, 12'hfff, 12'hfff, 1'b0, 0);     // R7 all ones
    run(3'd4, 12'd0, 12'h800, 12'h001, 1'b0, 0);     // R6 sign fill, R9 sc kept
    check("R9 sc after shift", 64'(sc_o), 64'(sc_model));
    run(3'd5, 12'd3, 12'h800, 12'h00f, 1'b0, 0);     // R6
    run(3'd3, 12'd23, 12'h000, 12'h001, 1'b0, 0);    // R5 link gets last bit
    run(3'd3, 12'hfff, 12'hfff, 12'hfff, 1'b0, 0);   // R12
    run(3'd4, 12'd24, 12'h800, 12'h000, 1'b0, 0);    // R12
    run(3'd0, 12'd9, 12'd0, 12'd13, 1'b0, 1);        // R10 start while busy

    // R11 unused codes
    for (int k = 6; k < 8; k++) begin
      a = ac_o;
      @(negedge clk_i);
      start_i = 1'b1; op_i = 3'(k); ac_i = ~a;
      @(negedge clk_i);
      start_i = 1'b0;
      check("R11 unused code ignored", {busy_o, ac_o}, {1'b0, a});
    end

    for (int k = 0; k < 300; k++) begin
      o = 3'($urandom_range(0, 5));
      a = 12'($urandom); b = 12'($urandom); c = 12'($urandom);
      if (o == 3'd1 && b != 0 && $urandom_range(0, 3) != 0) a = 12'(int'(a) % int'(b));
      if (o >= 3'd3 && $urandom_range(0, 1) == 1) b = 12'($urandom_range(0, 30));
      if (o == 3'd2 && $urandom_range(0, 1) == 1) begin a = 12'(a >> $urandom_range(0, 11)); end
      run(o, b, a, c, 1'($urandom), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule